// File: doc/BRIEF.md
# Zero-Operand Stack Expression Evaluator

This block evaluates arithmetic expressions written in postfix order. It takes one decoded command per accepted handshake. A push command carries an immediate value. Pop, add, subtract, multiply and divide carry no operand field. The arithmetic commands take both operands from the top of a last-in-first-out operand stack and place one result back on it.

The two topmost entries are kept in dedicated registers. Any entry below them spills into a small synchronous-read array, written so that it maps onto block RAM. A pop or an arithmetic command can expose an entry that lives in the array. When that happens, the block drops its ready output for one cycle while it refills the second register from the array.

The outputs are the current top value, the depth, a signed stack pointer (depth minus one) and three one-cycle error flags.

Top module: `stack_eval`

## Requirements
- R1: After synchronous reset the stack is empty: depth 0, stack pointer -1, top value 0, ready high and all error flags low.
- R2: A push (opcode 0) raises the depth and the stack pointer by one and shows its 16-bit immediate as the top value in the cycle after acceptance.
- R3: A pop (opcode 1) removes the top entry, so the entry that was below it becomes the top value. Popping the last entry leaves top value 0.
- R4: Add (opcode 2) and subtract (opcode 3) use the entry below the top as left operand and the top as right operand. Pushing 10, pushing 20 and then subtracting gives -10.
- R5: Multiply (opcode 4) keeps the low 16 bits of the two's-complement product. Divide (opcode 5) computes below/top, truncated toward zero.
- R6: A successful arithmetic command lowers the depth by exactly one. Entries deeper in the stack, including those held in the spill array, keep their values and order.
- R7: A pop on an empty stack, or an arithmetic command with fewer than two entries, raises the underflow flag for one cycle and leaves the depth and the top value unchanged.
- R8: A push while the depth equals DEPTH raises the overflow flag for one cycle and is ignored.
- R9: A divide whose top entry is zero raises the divide-by-zero flag for one cycle and leaves the stack unchanged.
- R10: After an accepted pop or arithmetic command that starts from a depth of three or more, ready is low for exactly one cycle. In every other case ready stays high.
- R11: The command sequence push 5, push 3, push 7, multiply, add, push 8, subtract leaves 18 as the only entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command this cycle |
| cmd_op | input | 3 | Opcode: 0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div |
| cmd_imm | input | DATA_W | Immediate value for push |
| top_value | output | DATA_W | Current top entry (0 when empty) |
| depth | output | $clog2(DEPTH+1) | Number of entries on the stack |
| stack_ptr | output | $clog2(DEPTH+1)+1 | Signed stack pointer, depth minus one |
| err_under | output | 1 | Underflow, one-cycle pulse |
| err_over | output | 1 | Overflow, one-cycle pulse |
| err_div0 | output | 1 | Divide by zero, one-cycle pulse |

## Verification
The bench builds the block with DATA_W of 16 and DEPTH of 5, which leaves a three-entry spill array. With that depth, a handful of pushes reaches the full-stack overflow case, and the same stack also fills the array. The reductions that follow then exercise the refill path and its ready bubble at each array address. The default depth of 16 would exercise the same logic with more commands and add no new case.

// File: rtl/stack_eval_pkg.sv
package stack_eval_pkg;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5
  } op_e;

  function automatic logic is_binary(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
  endfunction

endpackage

// File: rtl/stack_alu.sv
module stack_alu
  import stack_eval_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] lhs,   // entry below the top
  input  logic [DATA_W-1:0] rhs,   // top entry
  output logic [DATA_W-1:0] result,
  output logic              div_zero
);

  assign div_zero = (rhs == '0);

  always_comb begin
    result = '0;
    case (op)
      OP_ADD: result = lhs + rhs;
      OP_SUB: result = lhs - rhs;
      OP_MUL: result = lhs * rhs;          // low DATA_W bits of product
      OP_DIV: if (!div_zero) result = DATA_W'($signed(lhs) / $signed(rhs));
      default: result = '0;
    endcase
  end

  // R5: a zero divisor never reaches the divider output as a nonzero value
  always_comb begin
    if (op == OP_DIV && div_zero) begin
      a_r5_div_guard: assert (result == '0);
    end
  end

endmodule

// File: rtl/stack_spill_ram.sv
module stack_spill_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/stack_eval.sv
module stack_eval
  import stack_eval_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [2:0]                    cmd_op,
  input  logic [DATA_W-1:0]             cmd_imm,
  output logic [DATA_W-1:0]             top_value,
  output logic [$clog2(DEPTH+1)-1:0]    depth,
  output logic signed [$clog2(DEPTH+1):0] stack_ptr,
  output logic                          err_under,
  output logic                          err_over,
  output logic                          err_div0
);

  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int SPILL  = DEPTH - 2;
  localparam int ADDR_W = (SPILL > 1) ? $clog2(SPILL) : 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] top_q, next_q;
  logic [CNT_W-1:0]  count_q;
  logic              refill_q;
  logic              under_q, over_q, dz_q;

  logic [DATA_W-1:0] alu_res, ram_rd;
  logic              alu_dz;
  logic              accept, op_bin;
  logic              do_push, do_pop, do_bin;
  logic              hit_under, hit_over, hit_dz, need_refill;
  logic [CNT_W-1:0]  wr_idx, rd_idx;

  assign cmd_ready = !refill_q;
  assign accept    = cmd_valid && cmd_ready;
  assign op_bin    = is_binary(cmd_op);

  stack_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (cmd_op),
    .lhs      (next_q),
    .rhs      (top_q),
    .result   (alu_res),
    .div_zero (alu_dz)
  );

  assign hit_over  = accept && (cmd_op == OP_PUSH) && (count_q == FULL);
  assign hit_under = accept && (((cmd_op == OP_POP) && (count_q == '0)) ||
                                (op_bin && (count_q < CNT_W'(2))));
  assign hit_dz    = accept && (cmd_op == OP_DIV) && (count_q >= CNT_W'(2)) && alu_dz;
  assign do_push   = accept && (cmd_op == OP_PUSH) && !hit_over;
  assign do_pop    = accept && (cmd_op == OP_POP) && !hit_under;
  assign do_bin    = accept && op_bin && !hit_under && !hit_dz;
  assign need_refill = (do_pop || do_bin) && (count_q >= CNT_W'(3));

  // array slot k holds the entry at stack index k (index 0 is the bottom)
  assign wr_idx = count_q - CNT_W'(2);
  assign rd_idx = count_q - CNT_W'(3);

  stack_spill_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_spill (
    .clk     (clk),
    .wr_en   (do_push && (count_q >= CNT_W'(2))),
    .wr_addr (ADDR_W'(wr_idx)),
    .wr_data (next_q),
    .rd_addr (ADDR_W'(rd_idx)),
    .rd_data (ram_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q    <= '0;
      next_q   <= '0;
      count_q  <= '0;
      refill_q <= 1'b0;
      under_q  <= 1'b0;
      over_q   <= 1'b0;
      dz_q     <= 1'b0;
    end else begin
      under_q  <= hit_under;
      over_q   <= hit_over;
      dz_q     <= hit_dz;
      refill_q <= need_refill;
      if (refill_q) next_q <= ram_rd;
      if (do_push) begin
        top_q   <= cmd_imm;
        next_q  <= top_q;
        count_q <= count_q + 1'b1;
      end else if (do_pop) begin
        top_q   <= next_q;
        next_q  <= '0;
        count_q <= count_q - 1'b1;
      end else if (do_bin) begin
        top_q   <= alu_res;
        next_q  <= '0;
        count_q <= count_q - 1'b1;
      end
    end
  end

  assign top_value = top_q;
  assign depth     = count_q;
  assign stack_ptr = $signed({1'b0, count_q}) - $signed((CNT_W+1)'(1));
  assign err_under = under_q;
  assign err_over  = over_q;
  assign err_div0  = dz_q;

  // R8: depth never exceeds the configured limit
  a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL);

  // R8: push on a full stack is dropped and flagged
  a_r8_full_push: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_op == OP_PUSH && count_q == FULL) |=> (err_over && $stable(count_q)));

  // R7: underflow leaves depth and top alone
  a_r7_underflow_hold: assert property (@(posedge clk) disable iff (rst)
    (accept && op_bin && count_q < CNT_W'(2)) |=> (err_under && $stable(count_q) && $stable(top_q)));

  // R9: divide by zero keeps the stack as it was
  a_r9_div0_hold: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_op == OP_DIV && count_q >= CNT_W'(2) && top_q == '0)
      |=> (err_div0 && $stable(count_q) && $stable(top_q)));

  // R6: a successful reduction removes exactly one entry
  a_r6_reduce_one: assert property (@(posedge clk) disable iff (rst)
    (accept && op_bin && count_q >= CNT_W'(2) && !(cmd_op == OP_DIV && top_q == '0))
      |=> (count_q == $past(count_q) - 1'b1));

  // R10: the refill bubble lasts a single cycle
  a_r10_one_bubble: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |=> cmd_ready);

  // R7, R8, R9: at most one error flag per command
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_under, err_over, err_div0}));

endmodule

// File: tb/tb_stack_eval.sv
`timescale 1ns/1ps
module tb_stack_eval;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 5;
  localparam int CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [DATA_W-1:0] cmd_imm = '0;
  logic [DATA_W-1:0] top_value;
  logic [CW-1:0] depth;
  logic signed [CW:0] stack_ptr;
  logic err_under, err_over, err_div0;

  always #4 clk = ~clk;   // 125 MHz

  stack_eval #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_imm(cmd_imm), .top_value(top_value), .depth(depth),
    .stack_ptr(stack_ptr), .err_under(err_under), .err_over(err_over),
    .err_div0(err_div0)
  );

  int errors = 0;
  int checks = 0;

  // scoreboard queues (one entry per accepted command)
  string             q_req[$];
  logic [DATA_W-1:0] q_top[$];
  int                q_dep[$];
  logic [3:0]        q_flags[$];   // {ready, under, over, div0}

  logic signed [DATA_W-1:0] mstk[$];

  task automatic send(input logic [2:0] op, input logic [DATA_W-1:0] imm, input string req);
    int n;
    logic u, o, z, rdy;
    logic signed [DATA_W-1:0] a, b, r;
    n = mstk.size();
    u = 0; o = 0; z = 0; rdy = 1;
    case (op)
      3'd0: if (n == DEPTH) o = 1; else mstk.push_back(imm);
      3'd1: if (n == 0) u = 1; else begin void'(mstk.pop_back()); rdy = (n < 3); end
      default: begin
        if (n < 2) u = 1;
        else if (op == 3'd5 && mstk[n-1] == 0) z = 1;
        else begin
          b = mstk.pop_back();
          a = mstk.pop_back();
          case (op)
            3'd2: r = a + b;
            3'd3: r = a - b;
            3'd4: r = a * b;
            default: r = a / b;
          endcase
          mstk.push_back(r);
          rdy = (n < 3);
        end
      end
    endcase
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_imm   = imm;
    q_req.push_back(req);
    q_top.push_back(mstk.size() == 0 ? '0 : mstk[$]);
    q_dep.push_back(mstk.size());
    q_flags.push_back({rdy, u, o, z});
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // monitor
  logic fired = 1'b0;
  always @(posedge clk) fired <= cmd_valid && cmd_ready && !rst;

  always @(negedge clk) begin
    if (fired) begin
      string rq;
      logic [DATA_W-1:0] et;
      int ed;
      logic [3:0] ef;
      if (q_req.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: accepted command with no expected item");
      end else begin
        rq = q_req.pop_front();
        et = q_top.pop_front();
        ed = q_dep.pop_front();
        ef = q_flags.pop_front();
        checks++;
        if (top_value !== et || int'(depth) != ed || int'(stack_ptr) != ed - 1 ||
            {cmd_ready, err_under, err_over, err_div0} !== ef) begin
          errors++;
          $display("FAIL %s: top=%0d depth=%0d sp=%0d flags(rdy,u,o,z)=%b expected top=%0d depth=%0d sp=%0d flags=%b",
                   rq, $signed(top_value), depth, stack_ptr,
                   {cmd_ready, err_under, err_over, err_div0}, $signed(et), ed, ed - 1, ef);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;   // R1 reset state
    if (top_value !== '0 || depth !== '0 || int'(stack_ptr) != -1 || cmd_ready !== 1'b1 ||
        {err_under, err_over, err_div0} !== 3'b000) begin
      errors++;
      $display("FAIL R1: top=%0d depth=%0d sp=%0d ready=%b flags=%b expected 0 0 -1 1 000",
               top_value, depth, stack_ptr, cmd_ready, {err_under, err_over, err_div0});
    end

    // R11 worked expression
    send(3'd0, 16'd5, "R2 push");
    send(3'd0, 16'd3, "R2 push");
    send(3'd0, 16'd7, "R2 push");
    send(3'd4, 16'd0, "R11 mul");
    send(3'd2, 16'd0, "R11 add");
    send(3'd0, 16'd8, "R11 push");
    send(3'd3, 16'd0, "R11 sub gives 18");
    send(3'd1, 16'd0, "R3 pop last");

    // R4 operand order
    send(3'd0, 16'd10, "R4 push");
    send(3'd0, 16'd20, "R4 push");
    send(3'd3, 16'd0, "R4 sub gives -10");
    send(3'd0, 16'd9, "R4 push");
    send(3'd2, 16'd0, "R4 add");
    send(3'd1, 16'd0, "R3 pop");

    // R5 multiply wrap and divide truncation
    send(3'd0, 16'd300, "R5 push");
    send(3'd0, 16'd300, "R5 push");
    send(3'd4, 16'd0, "R5 mul low bits");
    send(3'd1, 16'd0, "R3 pop");
    send(3'd0, -16'sd7, "R5 push");
    send(3'd0, 16'd2, "R5 push");
    send(3'd5, 16'd0, "R5 div -7/2");
    send(3'd0, -16'sd2, "R5 push");
    send(3'd5, 16'd0, "R5 div -3/-2");
    send(3'd1, 16'd0, "R3 pop");

    // R9 divide by zero
    send(3'd0, 16'd5, "R9 push");
    send(3'd0, 16'd0, "R9 push zero");
    send(3'd5, 16'd0, "R9 div by zero");
    send(3'd1, 16'd0, "R9 pop after");
    send(3'd1, 16'd0, "R9 pop after");

    // R7 underflow
    send(3'd1, 16'd0, "R7 pop empty");
    send(3'd2, 16'd0, "R7 add empty");
    send(3'd0, 16'd1, "R7 push");
    send(3'd3, 16'd0, "R7 sub one entry");
    send(3'd1, 16'd0, "R7 pop");

    // R8 overflow, R6/R10 spill and refill
    for (int i = 1; i <= DEPTH; i++) send(3'd0, 16'(i), "R6 fill");
    send(3'd0, 16'd99, "R8 push on full");
    send(3'd3, 16'd0, "R10 sub with refill");
    send(3'd2, 16'd0, "R10 add with refill");
    send(3'd2, 16'd0, "R6 add with refill");
    send(3'd2, 16'd0, "R6 add from two");
    send(3'd1, 16'd0, "R3 pop");

    // R3 pops through the array
    send(3'd0, 16'd11, "R3 push");
    send(3'd0, 16'd22, "R3 push");
    send(3'd0, 16'd33, "R3 push");
    send(3'd0, 16'd44, "R3 push");
    send(3'd1, 16'd0, "R3 pop refill");
    send(3'd1, 16'd0, "R3 pop refill");
    send(3'd1, 16'd0, "R3 pop");
    send(3'd1, 16'd0, "R3 pop to empty");

    repeat (4) @(negedge clk);
    if (q_req.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: %0d expected items never produced", q_req.size());
    end
    finish_run();
  end

endmodule